// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel byte into an asynchronous serial frame on a single output line. A producer offers a word on a valid/ready input. When the word is taken, the block drives a low start bit, then the data field with the least significant bit first, then an optional parity bit, then one or two high stop bits. After that the line returns to its idle high level. Three run-time controls set the shape of the frame: the data width (seven or eight bits), the parity mode (none, even or odd) and the stop-bit count.

The bit period comes from a divider inside the block that counts reference-clock cycles. The period is set by a run-time divisor input. The divisor and all format controls are captured on the cycle a word is accepted, so changes made while a frame is on the line apply only to later frames. An optional hardware handshake blocks the start of a new frame while the far end's ready input is low. That input is looked at only when a frame is about to begin.

Top module: `serial_frame_tx`

## Requirements
- R1: While no frame is in progress the line `txd_o` is 1. Each frame begins with exactly one start bit at 0, driven from the first clock cycle after the accepting clock edge.
- R2: Data bits follow the start bit, least significant first. With `cfg_seven_i`=1 only bits 6..0 of the word are sent and bit 7 has no effect on the line. With `cfg_seven_i`=0 all eight bits are sent.
- R3: `cfg_par_i` encodes parity: 2'b00 or 2'b11 means no parity bit, 2'b01 means even, 2'b10 means odd. The even parity bit is the XOR of the data bits that are sent, and the odd parity bit is its inverse. The parity bit comes directly after the last data bit.
- R4: One stop bit (`cfg_two_stop_i`=0) or two stop bits (`cfg_two_stop_i`=1) at 1 end the frame. `busy_o` is 1 for exactly the length of the frame, and `in_ready_o` stays 0 during that time.
- R5: Every bit of the frame lasts `div_i`+1 clock cycles (`div_i`=0 gives one cycle per bit).
- R6: A word is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both 1. `in_ready_o` is 1 only when no frame is in progress and either `hs_en_i` is 0 or `cts_i` is 1.
- R7: `cts_i` is examined only when a frame is about to start. Dropping it during a frame neither stops nor alters that frame.
- R8: The data word, format controls and divisor are captured on the accepting edge. Changing them during a frame does not change that frame.
- R9: After reset, `txd_o` is 1, `busy_o` is 0, and `in_ready_o` reflects R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_i | input | 16 | Bit period minus one, in clock cycles |
| cfg_seven_i | input | 1 | 1: seven data bits, 0: eight data bits |
| cfg_par_i | input | 2 | Parity mode: 00/11 none, 01 even, 10 odd |
| cfg_two_stop_i | input | 1 | 1: two stop bits, 0: one stop bit |
| hs_en_i | input | 1 | Enables gating of frame start by `cts_i` |
| cts_i | input | 1 | Far-end ready (active high) |
| in_valid_i | input | 1 | Word offered |
| in_data_i | input | 8 | Word to send |
| in_ready_o | output | 1 | Block can accept a word this cycle |
| txd_o | output | 1 | Serial line |
| busy_o | output | 1 | Frame in progress |

## Verification
If the shift register or the bit counter held a wrong value, a bit sampled at the middle of its period would differ from the frame the bench builds for that format. The error shows within one bit period of the faulty state. A wrong remaining-bit count shows up on `busy_o` as a frame that ends early or late, and also on `in_ready_o`. A wrong divisor count makes the line move away from the expected mid-bit samples within a bit or two. A missed capture of the controls shows as a wrong frame in the same cycles in which the bench changes them in the middle of a frame.

// File: rtl/sftx_pkg.sv
// Shared constants and types for the serial frame transmitter.
// Assumes a data word of at most eight bits and at most two stop bits.
package sftx_pkg;
    localparam int DATA_MAX  = 8;
    localparam int FRAME_MAX = 1 + DATA_MAX + 1 + 2;
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);

    typedef enum logic [1:0] {
        PAR_NONE  = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_ODD   = 2'b10,
        PAR_NONE2 = 2'b11
    } par_mode_e;
endpackage

// File: rtl/sftx_baud.sv
// Bit-period divider. Pulses tick_o on the last cycle of every bit period.
// A period is div_i+1 cycles. restart_i realigns the count to the start of a
// frame. Assumes div_i is held stable by the caller for the whole frame.
module sftx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == div_i);

    // Count cycles within the current bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= (cnt_q == div_i) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sftx_framer.sv
// Combinational frame builder. Places start, data (LSB first), optional
// parity and stop bits into a vector whose bit 0 is sent first. Unused upper
// positions are 1. Assumes the caller loads the result on the accepting edge.
module sftx_framer
    import sftx_pkg::*;
(
    input  logic [DATA_MAX-1:0]  data_i,
    input  logic                 seven_i,
    input  logic [1:0]           par_i,
    input  logic                 two_stop_i,
    output logic [FRAME_MAX-1:0] bits_o,
    output logic [LEN_W-1:0]     len_o
);
    logic [DATA_MAX-1:0] mask;
    logic                even_bit;
    logic                has_par;
    int                  ndata;

    // Build the frame vector and its length.
    always_comb begin
        ndata    = seven_i ? DATA_MAX - 1 : DATA_MAX;
        mask     = seven_i ? {1'b0, {(DATA_MAX-1){1'b1}}} : {DATA_MAX{1'b1}};
        even_bit = ^(data_i & mask);
        has_par  = (par_i == PAR_EVEN) || (par_i == PAR_ODD);
        bits_o   = '1;
        bits_o[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < ndata) bits_o[1 + i] = data_i[i];
        end
        if (has_par) bits_o[1 + ndata] = (par_i == PAR_ODD) ? ~even_bit : even_bit;
        len_o = LEN_W'(1 + ndata + (has_par ? 1 : 0) + (two_stop_i ? 2 : 1));
    end
endmodule

// File: rtl/sftx_seq.sv
// Frame sequencer. Holds the frame in a shift register and drives bit 0 of it
// onto the line. Shifts once per bit tick and counts down the remaining bits.
// Assumes load_i is only raised while idle.
module sftx_seq
    import sftx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [FRAME_MAX-1:0] bits_i,
    input  logic [LEN_W-1:0]     len_i,
    input  logic                 tick_i,
    output logic                 line_o,
    output logic                 busy_o
);
    logic [FRAME_MAX-1:0] shreg_q;
    logic [LEN_W-1:0]     left_q;
    logic                 busy_q;

    assign line_o = shreg_q[0];
    assign busy_o = busy_q;

    // Load a new frame, or step to the next bit at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '1;
            left_q  <= '0;
            busy_q  <= 1'b0;
        end else if (load_i) begin
            shreg_q <= bits_i;
            left_q  <= len_i;
            busy_q  <= 1'b1;
        end else if (busy_q && tick_i) begin
            shreg_q <= {1'b1, shreg_q[FRAME_MAX-1:1]};
            left_q  <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) busy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_frame_tx.sv
// Top level of the configurable serial transmitter. Accepts a word on a
// valid/ready handshake, gated by the optional far-end ready, and captures
// the format and the divisor for the frame. Assumes all inputs are
// synchronous to clk.
module serial_frame_tx
    import sftx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    div_i,
    input  logic                cfg_seven_i,
    input  logic [1:0]          cfg_par_i,
    input  logic                cfg_two_stop_i,
    input  logic                hs_en_i,
    input  logic                cts_i,
    input  logic                in_valid_i,
    input  logic [DATA_MAX-1:0] in_data_i,
    output logic                in_ready_o,
    output logic                txd_o,
    output logic                busy_o
);
    logic                 accept;
    logic                 bit_tick;
    logic                 busy;
    logic [DIV_W-1:0]     div_q;
    logic [FRAME_MAX-1:0] frame_bits;
    logic [LEN_W-1:0]     frame_len;

    assign in_ready_o = !busy && (!hs_en_i || cts_i);
    assign accept     = in_valid_i && in_ready_o;
    assign busy_o     = busy;

    // Capture the divisor when a frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (accept) div_q <= div_i;
    end

    sftx_framer u_framer (
        .data_i     (in_data_i),
        .seven_i    (cfg_seven_i),
        .par_i      (cfg_par_i),
        .two_stop_i (cfg_two_stop_i),
        .bits_o     (frame_bits),
        .len_o      (frame_len)
    );

    sftx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (accept),
        .run_i     (busy),
        .div_i     (div_q),
        .tick_o    (bit_tick)
    );

    sftx_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .bits_i (frame_bits),
        .len_i  (frame_len),
        .tick_i (bit_tick),
        .line_o (txd_o),
        .busy_o (busy)
    );
endmodule

// File: rtl/sftx_checker.sv
// Property checker for serial_frame_tx, attached with bind. Watches the ports
// and the internal bit tick. Assumes synchronous active-low reset.
module sftx_checker (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic txd_o,
    input logic in_ready_o,
    input logic hs_en_i,
    input logic cts_i,
    input logic bit_tick
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> txd_o);

    assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !txd_o);

    assert_no_ready_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !in_ready_o);

    assert_hold_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$past(bit_tick)) |-> $stable(txd_o));

    assert_end_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(bit_tick));

    assert_cts_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_o) && $past(hs_en_i)) |-> $past(cts_i));
endmodule

bind serial_frame_tx sftx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .txd_o      (txd_o),
    .in_ready_o (in_ready_o),
    .hs_en_i    (hs_en_i),
    .cts_i      (cts_i),
    .bit_tick   (bit_tick)
);

// File: tb/serial_frame_tx_test.sv
`timescale 1ns/1ps
module serial_frame_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div_i = 16'd3;
    logic        cfg_seven_i = 1'b0;
    logic [1:0]  cfg_par_i = 2'b00;
    logic        cfg_two_stop_i = 1'b0;
    logic        hs_en_i = 1'b0;
    logic        cts_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [7:0]  in_data_i = 8'h00;
    logic        in_ready_o, txd_o, busy_o;

    int errors = 0;
    int checks = 0;
    logic [11:0] last_got;
    int          last_len;

    always #2.5 clk = ~clk;

    serial_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .div_i(div_i), .cfg_seven_i(cfg_seven_i),
        .cfg_par_i(cfg_par_i), .cfg_two_stop_i(cfg_two_stop_i),
        .hs_en_i(hs_en_i), .cts_i(cts_i), .in_valid_i(in_valid_i),
        .in_data_i(in_data_i), .in_ready_o(in_ready_o), .txd_o(txd_o),
        .busy_o(busy_o)
    );

    // Reference frame, bit 0 sent first, from R1..R4.
    function automatic void model(input logic [7:0] d, input logic sev,
                                  input logic [1:0] p, input logic two,
                                  output logic [11:0] f, output int len);
        int n;
        logic par;
        f = '1;
        n = 0;
        f[n] = 1'b0; n++;
        par = 1'b0;
        for (int i = 0; i < (sev ? 7 : 8); i++) begin
            f[n] = d[i]; par = par ^ d[i]; n++;
        end
        if (p == 2'b01) begin f[n] = par;  n++; end
        if (p == 2'b10) begin f[n] = ~par; n++; end
        n += two ? 2 : 1;
        len = n;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one frame and compare the line at mid-bit against the model.
    task automatic send(input logic [7:0] d, input logic sev, input logic [1:0] p,
                        input logic two, input logic [15:0] dv,
                        input bit scramble, input bit hs);
        logic [11:0] exp_f;
        int          exp_len;
        int          dd;
        bit          bad_busy;
        bit          stall_ok;
        model(d, sev, p, two, exp_f, exp_len);
        dd = int'(dv) + 1;
        @(negedge clk);
        in_data_i = d; cfg_seven_i = sev; cfg_par_i = p; cfg_two_stop_i = two;
        div_i = dv; hs_en_i = hs; cts_i = hs ? 1'b0 : 1'($urandom_range(0, 1));
        in_valid_i = 1'b1;
        if (hs) begin
            stall_ok = 1'b1;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (in_ready_o !== 1'b0 || busy_o !== 1'b0 || txd_o !== 1'b1) stall_ok = 1'b0;
            end
            check(stall_ok, "R6 held by cts", {29'd0, in_ready_o, busy_o, txd_o}, 32'd1);
            cts_i = 1'b1;
        end
        while (in_ready_o !== 1'b1) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid_i = 1'b0;
        last_got = '1;
        bad_busy = 1'b0;
        for (int n = 0; n < exp_len * dd; n++) begin
            if (n % dd == dd / 2) last_got[n / dd] = txd_o;
            if (busy_o !== 1'b1 || in_ready_o !== 1'b0) bad_busy = 1'b1;
            if (n == dd) begin
                if (hs) cts_i = 1'b0;       // R7: frame must still complete
                if (scramble) begin         // R8: changes must not affect frame
                    in_data_i = 8'($urandom); cfg_seven_i = 1'($urandom);
                    cfg_par_i = 2'($urandom); cfg_two_stop_i = 1'($urandom);
                    div_i = 16'($urandom_range(0, 9));
                end
            end
            @(negedge clk);
        end
        last_len = exp_len;
        check(last_got == exp_f, "R2/R3 frame bits", {20'd0, last_got}, {20'd0, exp_f});
        check(!bad_busy, "R4 busy for frame", 32'(bad_busy), 32'd0);
        check(busy_o === 1'b0 && txd_o === 1'b1, "R5 frame length",
              {30'd0, busy_o, txd_o}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(txd_o === 1'b1 && busy_o === 1'b0 && in_ready_o === 1'b1, "R9 reset",
              {29'd0, txd_o, busy_o, in_ready_o}, 32'd5);
        // R1 idle line high
        repeat (5) @(negedge clk);
        check(txd_o === 1'b1, "R1 idle", 32'(txd_o), 32'd1);

        // Directed: 0xA0 no parity, 8 bits, 1 stop
        send(8'hA0, 1'b0, 2'b00, 1'b0, 16'd3, 1'b0, 1'b0);
        check(last_len == 10 && last_got[9:0] == 10'b1_10100000_0, "R2 A0 N81",
              {22'd0, last_got[9:0]}, 32'b1_10100000_0);
        // Directed: 0x67 even parity, 8 bits, 2 stop
        send(8'h67, 1'b0, 2'b01, 1'b1, 16'd4, 1'b0, 1'b0);
        check(last_len == 12 && last_got == 12'b11_1_01100111_0, "R3 67 E82",
              {20'd0, last_got}, 32'b11_1_01100111_0);
        // R2 seven bits: bit 7 ignored
        send(8'hFF, 1'b1, 2'b00, 1'b0, 16'd2, 1'b0, 1'b0);
        check(last_got[9] === 1'b1 && last_got[8] === 1'b1, "R2 seven-bit stop",
              {30'd0, last_got[9:8]}, 32'd3);
        // R3 odd parity with the fourth code, and R5 with div 0
        send(8'h01, 1'b0, 2'b10, 1'b0, 16'd0, 1'b0, 1'b0);
        send(8'h55, 1'b0, 2'b11, 1'b1, 16'd1, 1'b0, 1'b0);
        // R6/R7 handshake
        send(8'h3C, 1'b1, 2'b01, 1'b1, 16'd3, 1'b0, 1'b1);
        // R8 mid-frame change
        send(8'hC3, 1'b0, 2'b10, 1'b1, 16'd5, 1'b1, 1'b0);

        for (int t = 0; t < 120; t++) begin
            send(8'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                 16'($urandom_range(0, 9)), 1'($urandom_range(0, 3) == 0),
                 1'($urandom_range(0, 4) == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule